// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sets the feedback division ratio of a frequency synthesizer loop built around an external two-ratio prescaler. It runs on the prescaler's output clock and holds two loadable down-counters: a main counter (N) and a swallow counter (A). Its modulus-select output tells the prescaler which ratio to use. While the swallow counter is still running, the select is low and the prescaler divides by P+1. Once the swallow counter has run out, the select is high and the prescaler divides by P. Each full cycle therefore spans A·(P+1) + (N−A)·P = N·P + A input periods. The block marks the end of each cycle with a one-clock divided-frequency pulse. That pulse can drive a phase comparator, or it can be used on its own as a plain divider output.

The N and A values come in through a parallel port and are held in shadow registers on a write strobe. The running counters take new values only when a cycle reloads, so a cycle in progress is never shortened or stretched. The shadow registers repair illegal settings as they are captured: N = 0 is treated as 1, and an A larger than N is reduced to N.

Top module: `dual_mod_swallow_ctl`

## Requirements
- R1: On a clock edge with `rst_n` low, both counters load the repaired `cfg_n`/`cfg_a` values. The shadow registers take the same values. The state that follows is the first state of a cycle: `mod_ctl` is low when the effective A > 0, and `div_out` is high only when the effective N is 1.
- R2: In each cycle, `mod_ctl` is low for the first A prescaler clocks (states 0 to A−1).
- R3: After those A clocks, `mod_ctl` is high for the remaining N−A clocks. Once high, it stays high until the cycle's last state.
- R4: Each cycle lasts exactly N clocks. `div_out` is high for exactly one clock, in the last state (state N−1). On the next edge both counters reload from the shadow registers.
- R5: With an effective A of 0, `mod_ctl` is high in every state of the cycle, including the first.
- R6: When `cfg_wr` is high at an edge, the shadow registers capture the values. The running cycle continues with its old values, and the new values start at the first reload after that edge. A write captured on the reload edge itself first applies to the reload that follows.
- R7: Values are repaired when captured. N = 0 becomes 1, so `div_out` is high on every clock. An A greater than N becomes N, so `mod_ctl` stays low for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; all state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads counters and shadows from the cfg inputs |
| cfg_wr | input | 1 | Write strobe for the shadow N and A registers |
| cfg_n | input | W | Programmed main-counter value N |
| cfg_a | input | W | Programmed swallow-counter value A |
| mod_ctl | output | 1 | Prescaler ratio select: 0 selects P+1, 1 selects P |
| div_out | output | 1 | One-clock pulse in the last state of every cycle |

## Verification
Both outputs are decoded directly from the counter registers, so each output reflects the state loaded or stepped at the most recent rising edge. The bench drives inputs and samples outputs at falling edges. It numbers the states 0 to N−1 within a cycle and compares the outputs in each state against a model of that state index. A shadow write raised at a falling edge is captured at the next rising edge. Its effect is expected only from the state following the next reload. The bench checks this both for a write in the middle of a cycle and for a write that lands on the reload edge.

// File: rtl/swc_pkg.sv
// Shared definitions for the swallow counter controller.
// Assumes nothing beyond standard SystemVerilog.
package swc_pkg;

    // Which part of the count cycle the controller is in.
    typedef enum logic {
        PH_SWALLOW = 1'b0,   // swallow counter still running, prescaler at P+1
        PH_MAIN    = 1'b1    // swallow done, prescaler at P
    } swc_phase_e;

endpackage

// File: rtl/swc_prog_regs.sv
// Shadow registers for the programmed N and A values.
// Repairs illegal settings (N = 0 becomes 1, A > N becomes N) as values are captured.
// During reset, the load outputs pass the repaired inputs straight through,
// so the counters start from the current inputs.
// Assumes cfg_n and cfg_a are stable whenever cfg_wr or reset is active.
module swc_prog_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_n,
    input  logic [W-1:0] cfg_a,
    output logic [W-1:0] n_ld,
    output logic [W-1:0] a_ld
);
    localparam logic [W-1:0] VAL_ONE = 1;

    logic [W-1:0] n_fix, a_fix;
    logic [W-1:0] n_q, a_q;

    // Repair the incoming pair so that 1 <= N and A <= N.
    always_comb begin
        n_fix = (cfg_n == '0) ? VAL_ONE : cfg_n;
        a_fix = (cfg_a > n_fix) ? n_fix : cfg_a;
    end

    // Capture on reset or on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr) begin
            n_q <= n_fix;
            a_q <= a_fix;
        end
    end

    // Values the counters take at their next load.
    always_comb begin
        n_ld = rst_n ? n_q : n_fix;
        a_ld = rst_n ? a_q : a_fix;
    end

    // The stored pair always satisfies the repair rules.
    assert_pair_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q != '0) && (a_q <= n_q));

endmodule

// File: rtl/swc_down_counter.sv
// Loadable down-counter that stops at zero.
// Loads load_val on reset or on load; otherwise decrements until it reaches zero.
// Assumes load_val is stable during the cycle in which it is loaded.
module swc_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] STEP = 1;

    // Load, or count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - STEP;
        end
    end

    // A load puts the requested value into the counter.
    assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/dual_mod_swallow_ctl.sv
// Dual-modulus swallow counter controller.
// Both counters run on the prescaler output clock. mod_ctl is low while the
// swallow counter is non-zero and high after it runs out. div_out pulses in the
// last state of the N-clock cycle, and that pulse reloads both counters.
// Assumes a synchronous, active-low reset and cfg inputs held stable during reset.
module dual_mod_swallow_ctl
    import swc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_n,
    input  logic [W-1:0] cfg_a,
    output logic         mod_ctl,
    output logic         div_out
);
    localparam logic [W-1:0] LAST_N = 1;

    logic [W-1:0] n_ld, a_ld;
    logic [W-1:0] n_cnt, a_cnt;
    logic         reload;
    swc_phase_e   phase;

    swc_prog_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .cfg_n  (cfg_n),
        .cfg_a  (cfg_a),
        .n_ld   (n_ld),
        .a_ld   (a_ld)
    );

    swc_down_counter #(.W(W)) u_main_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (n_ld),
        .cnt      (n_cnt)
    );

    swc_down_counter #(.W(W)) u_swallow_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (a_ld),
        .cnt      (a_cnt)
    );

    // The main counter's terminal state ends the cycle and requests a reload.
    always_comb begin
        div_out = (n_cnt == LAST_N);
        reload  = div_out;
    end

    // Prescaler ratio follows the swallow counter's progress.
    always_comb begin
        phase   = (a_cnt == '0) ? PH_MAIN : PH_SWALLOW;
        mod_ctl = (phase == PH_MAIN);
    end

    // Once high, the select stays high until the cycle ends.
    assert_select_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ctl && !div_out) |=> mod_ctl);

    // The select rises only as the swallow count runs out.
    assert_select_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(mod_ctl)) |-> ($past(a_cnt) == LAST_N));

    // Reloading a swallow count of zero starts the cycle with the select high.
    assert_zero_swallow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_out && (a_ld == '0)) |=> mod_ctl);

endmodule

// File: tb/dual_mod_swallow_ctl_tb.sv
module dual_mod_swallow_ctl_tb;
    localparam int W = 8;

    typedef struct packed {
        int n_in;
        int a_in;
        int n_eff;
        int a_eff;
    } vec_t;

    // Programmed pair and the effective pair the repair rules predict.
    localparam vec_t VECS [8] = '{
        '{5, 2, 5, 2},   // R2 R3 R4 normal
        '{9, 1, 9, 1},   // R2 R3 R4
        '{6, 0, 6, 0},   // R5 zero swallow
        '{4, 4, 4, 4},   // R2 A equals N
        '{3, 7, 3, 3},   // R7 A clamped to N
        '{0, 0, 1, 0},   // R7 N of zero
        '{0, 3, 1, 1},   // R7 both repaired
        '{2, 1, 2, 1}    // R4 short cycle
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [W-1:0] cfg_n = '0;
    logic [W-1:0] cfg_a = '0;
    logic         mod_ctl, div_out;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    dual_mod_swallow_ctl #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_n   (cfg_n),
        .cfg_a   (cfg_a),
        .mod_ctl (mod_ctl),
        .div_out (div_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Check outputs for state index i of a cycle with effective n, a.
    task automatic chk_state(input string req, input int i, input int n, input int a);
        chk(req, $sformatf("mod_ctl n=%0d a=%0d state %0d", n, a, i), int'(mod_ctl), (i >= a) ? 1 : 0);
        chk(req, $sformatf("div_out n=%0d a=%0d state %0d", n, a, i), int'(div_out), (i == n - 1) ? 1 : 0);
    endtask

    // Check states from..to-1, advancing one clock after each.
    task automatic run_part(input string req, input int n, input int a, input int from, input int to);
        for (int i = from; i < to; i++) begin
            chk_state(req, i, n, a);
            @(negedge clk);
        end
    endtask

    // Apply reset with given inputs; checks the first state while in reset (R1).
    task automatic do_reset(input int n_in, input int a_in, input int n_eff, input int a_eff);
        @(negedge clk);
        cfg_n = W'(n_in);
        cfg_a = W'(a_in);
        rst_n = 1'b0;
        @(negedge clk);
        chk_state("R1", 0, n_eff, a_eff);
        rst_n = 1'b1;
    endtask

    // Raise a shadow write at the current falling edge, check state i, drop it at the next.
    task automatic write_at(input int n_new, input int a_new, input int i, input int n, input int a);
        cfg_n  = W'(n_new);
        cfg_a  = W'(a_new);
        cfg_wr = 1'b1;
        chk_state("R6", i, n, a);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        // Vector table: reset into each pair, then two full cycles.
        for (int k = 0; k < 8; k++) begin
            do_reset(VECS[k].n_in, VECS[k].a_in, VECS[k].n_eff, VECS[k].a_eff);
            run_part("R4", VECS[k].n_eff, VECS[k].a_eff, 0, VECS[k].n_eff);
            run_part("R2_R3", VECS[k].n_eff, VECS[k].a_eff, 0, VECS[k].n_eff);
        end

        // R6: a write in the middle of a cycle does not disturb it.
        do_reset(5, 2, 5, 2);
        run_part("R6", 5, 2, 0, 2);
        write_at(3, 1, 2, 5, 2);
        run_part("R6", 5, 2, 3, 5);
        run_part("R6", 3, 1, 0, 3);
        run_part("R6", 3, 1, 0, 2);

        // R6: a write captured on the reload edge waits one more cycle.
        write_at(6, 0, 2, 3, 1);
        run_part("R6", 3, 1, 0, 3);
        run_part("R5", 6, 0, 0, 6);
        run_part("R5", 6, 0, 0, 6);

        // R7: a write with A > N is clamped at capture.
        write_at(2, 9, 0, 6, 0);
        run_part("R7", 6, 0, 1, 6);
        run_part("R7", 2, 2, 0, 2);

        // R1: reset in the middle of a cycle restarts at once.
        do_reset(4, 1, 4, 1);
        run_part("R1", 4, 1, 0, 2);
        do_reset(7, 3, 7, 3);
        run_part("R1", 7, 3, 0, 7);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule